// File: doc/BRIEF.md
# Latched PWM Control Acceptance

This block turns an already conditioned control input into a held control signal for a PWM generator. When the source is high and the selected qualifier is true, a latch goes active. It stays active until a chosen termination event occurs, and only if that event also passes a second, independently selected termination qualifier.

Termination is normally deferred to the PWM end-of-cycle strobe, so a running pulse is never cut short. A control input can make termination immediate instead. The default terminator is a software request. That request passes through one staging register, so it must arrive at least two clocks before an end-of-cycle to take effect there. One of the generator's PWM outputs can be chosen as a signal. It is offered to the qualifier, the terminator and the termination qualifier multiplexers.

Top module: `pwm_latch_accept`

## Requirements
- R1: The output `active` rises at the clock edge that samples `src_in` high with the qualifier true. Nothing else can make it rise.
- R2: The qualifier is selected by `qual_sel`: 0 is always true, 1 is `duty_act`, 2 is `blank_act`, 3 is `gen_trig`, 4 is the selected PWM output, 5 is `ext_qual`, and 6 and 7 are always false.
- R3: The selected PWM output is `pwm_outs[pwm_sel]`. The same bit feeds the qualifier (code 4), the terminator (code 5) and the termination qualifier (code 4).
- R4: The terminator is selected by `term_sel`: 0 is the staged software request, 1 is `trig_a`, 2 is `trig_b`, 3 is `trig_c`, 4 is a falling edge of `src_in` (low now, high at the previous edge), 5 is the selected PWM output, 6 is `ext_term`, and 7 is none. Unselected terminator inputs have no effect.
- R5: A termination request is the terminator ANDed with the termination qualifier. `tq_sel` uses the same codes as R2, except that code 5 is `tq_ext`.
- R6: With `sync_dis` low, a request sampled at one edge clears `active` at the first later edge that samples `eoc` high. An `eoc` at the same edge as the request does not apply it.
- R7: With `sync_dis` high, a request clears `active` at the same edge that samples it.
- R8: `sw_term` sampled at edge k forms a request at edge k+1. With `eoc` sampled at k+1, nothing happens until a later `eoc`. With `eoc` sampled at k+2 or later, the latch clears. With `sync_dis` high, the latch clears at k+1.
- R9: When the set condition and a clear meet at the same edge, `active` stays high, and the pending request is still used up.
- R10: A deferred request stays pending until an `eoc` edge, including while `active` is low, and is discarded at that edge.
- R11: Reset (`rst_n` low) clears `active` and any pending request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_in | input | 1 | Conditioned control source |
| qual_sel | input | 3 | Qualifier select |
| duty_act | input | 1 | Duty cycle active event |
| blank_act | input | 1 | Blanking active event |
| gen_trig | input | 1 | Generator triggered event |
| ext_qual | input | 1 | External qualifier input |
| pwm_outs | input | NPWM (8) | PWM outputs available for selection |
| pwm_sel | input | $clog2(NPWM) (3) | Index of the selected PWM output |
| term_sel | input | 3 | Terminator select |
| sw_term | input | 1 | Software terminate write strobe |
| trig_a | input | 1 | Trigger A event |
| trig_b | input | 1 | Trigger B event |
| trig_c | input | 1 | Trigger C event |
| ext_term | input | 1 | External terminator input |
| tq_sel | input | 3 | Termination qualifier select |
| tq_ext | input | 1 | External termination qualifier input |
| eoc | input | 1 | PWM end-of-cycle strobe |
| sync_dis | input | 1 | High: terminate immediately, not at end-of-cycle |
| active | output | 1 | Latched control output |

## Verification
The hardest state to reach from the ports is a pending request that is invisible at the output. This covers a request made while the latch is idle, a request consumed in the same edge as a set, and a request left over when reset arrives. The bench builds each case with a fixed cycle script: it issues the request, then sets the latch a cycle later, and only then raises `eoc`. The hidden pending bit shows up in whether `active` falls. The software-request timing is probed the same way, with `eoc` placed exactly one and then two edges after the write.

// File: rtl/pwm_latch_accept.sv
`timescale 1ns/1ps
module pwm_latch_accept #(
  parameter int NPWM = 8,
  parameter int SELW = $clog2(NPWM)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            src_in,
  input  logic [2:0]      qual_sel,
  input  logic            duty_act,
  input  logic            blank_act,
  input  logic            gen_trig,
  input  logic            ext_qual,
  input  logic [NPWM-1:0] pwm_outs,
  input  logic [SELW-1:0] pwm_sel,
  input  logic [2:0]      term_sel,
  input  logic            sw_term,
  input  logic            trig_a,
  input  logic            trig_b,
  input  logic            trig_c,
  input  logic            ext_term,
  input  logic [2:0]      tq_sel,
  input  logic            tq_ext,
  input  logic            eoc,
  input  logic            sync_dis,
  output logic            active
);

  logic src_d, sw_stg, pend;
  logic qual, tqual, tev;

  wire pwm_pick = pwm_outs[pwm_sel];
  wire fell     = src_d & ~src_in;

  always_comb begin
    case (qual_sel)
      3'd0:    qual = 1'b1;
      3'd1:    qual = duty_act;
      3'd2:    qual = blank_act;
      3'd3:    qual = gen_trig;
      3'd4:    qual = pwm_pick;
      3'd5:    qual = ext_qual;
      default: qual = 1'b0;
    endcase
  end

  always_comb begin
    case (tq_sel)
      3'd0:    tqual = 1'b1;
      3'd1:    tqual = duty_act;
      3'd2:    tqual = blank_act;
      3'd3:    tqual = gen_trig;
      3'd4:    tqual = pwm_pick;
      3'd5:    tqual = tq_ext;
      default: tqual = 1'b0;
    endcase
  end

  always_comb begin
    case (term_sel)
      3'd0:    tev = sw_stg;
      3'd1:    tev = trig_a;
      3'd2:    tev = trig_b;
      3'd3:    tev = trig_c;
      3'd4:    tev = fell;
      3'd5:    tev = pwm_pick;
      3'd6:    tev = ext_term;
      default: tev = 1'b0;
    endcase
  end

  wire set_c = src_in & qual;
  wire req   = tev & tqual;
  wire clr   = sync_dis ? req : (eoc & pend);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_d  <= 1'b0;
      sw_stg <= 1'b0;
      pend   <= 1'b0;
      active <= 1'b0;
    end else begin
      src_d  <= src_in;
      sw_stg <= sw_term;
      pend   <= ~sync_dis & ((pend & ~eoc) | req);
      active <= set_c | (active & ~clr);
    end
  end

endmodule

module pwm_latch_accept_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       src_in,
  input logic [2:0] qual_sel,
  input logic [2:0] term_sel,
  input logic [2:0] tq_sel,
  input logic       trig_a,
  input logic       eoc,
  input logic       sync_dis,
  input logic       active
);

  p_rise_needs_src_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> $past(src_in));

  p_open_qual_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (src_in && qual_sel == 3'd0) |=> active);

  p_none_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (active && sync_dis && term_sel == 3'd7) |=> active);

  p_sync_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !sync_dis && !eoc) |=> active);

  p_immediate_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_dis && term_sel == 3'd1 && tq_sel == 3'd0 && trig_a && !src_in) |=> !active);

endmodule

bind pwm_latch_accept pwm_latch_accept_chk u_chk (.*);

// File: tb/tb_pwm_latch_accept.sv
`timescale 1ns/1ps
module tb_pwm_latch_accept;

  logic clk = 1'b0;
  logic rst_n;
  logic src_in, duty_act, blank_act, gen_trig, ext_qual;
  logic [7:0] pwm_outs;
  logic [2:0] pwm_sel, qual_sel, term_sel, tq_sel;
  logic sw_term, trig_a, trig_b, trig_c, ext_term, tq_ext, eoc, sync_dis;
  logic active;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  pwm_latch_accept dut (.*);

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    src_in = 0; duty_act = 0; blank_act = 0; gen_trig = 0; ext_qual = 0;
    pwm_outs = 8'h00; sw_term = 0; trig_a = 0; trig_b = 0; trig_c = 0;
    ext_term = 0; tq_ext = 0; eoc = 0;
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic clear_latch();
    logic [2:0] ts, tq; logic sd;
    ts = term_sel; tq = tq_sel; sd = sync_dis;
    idle(); sync_dis = 1; term_sel = 3'd1; tq_sel = 3'd0; trig_a = 1;
    tick(); idle(); tick();
    term_sel = ts; tq_sel = tq; sync_dis = sd;
  endtask

  task automatic set_latch();
    logic [2:0] qs;
    qs = qual_sel; qual_sel = 3'd0; src_in = 1;
    tick(); src_in = 0; qual_sel = qs;
  endtask

  function automatic logic selv(input logic [2:0] s, input logic [4:0] p);
    case (s)
      3'd0: return 1'b1;
      3'd1: return p[0];
      3'd2: return p[1];
      3'd3: return p[2];
      3'd4: return p[3];
      3'd5: return p[4];
      default: return 1'b0;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle();
    rst_n = 0; qual_sel = 0; term_sel = 7; tq_sel = 0; pwm_sel = 0; sync_dis = 1;
    tick(); tick();
    chk("R11 reset", active, 1'b0);
    rst_n = 1;
    tick();
    chk("R11 after reset", active, 1'b0);

    // R2 qualifier sweep
    term_sel = 3'd7; pwm_sel = 3'd3;
    for (int qs = 0; qs < 8; qs++) begin
      for (int p = 0; p < 32; p++) begin
        logic [4:0] pv;
        pv = p[4:0];
        clear_latch();
        qual_sel = qs[2:0];
        duty_act = pv[0]; blank_act = pv[1]; gen_trig = pv[2];
        pwm_outs = pv[3] ? 8'h08 : 8'hF7; ext_qual = pv[4]; tq_ext = ~pv[4];
        src_in = 1;
        tick(); idle();
        chk("R2 qualifier", active, selv(qs[2:0], pv));
      end
    end

    // R3 pwm select for qualifier
    qual_sel = 3'd4;
    for (int s = 0; s < 8; s++) begin
      for (int v = 0; v < 2; v++) begin
        clear_latch();
        pwm_sel = s[2:0];
        pwm_outs = (v == 1) ? (8'h01 << s) : ~(8'h01 << s);
        src_in = 1;
        tick(); idle();
        chk("R3 pwm select", active, v == 1);
      end
    end

    // R4 terminator sweep, immediate mode
    qual_sel = 3'd0; tq_sel = 3'd0; sync_dis = 1;
    for (int ts = 0; ts < 8; ts++) begin
      logic [2:0] sel;
      sel = ts[2:0] ^ 3'd3;
      term_sel = ts[2:0]; pwm_sel = sel;
      clear_latch();
      src_in = 1; tick(); src_in = 0; tick();
      chk("R4 auto edge", active, ts != 4);
      if (ts != 4) begin
        sw_term = (ts != 0); trig_a = (ts != 1); trig_b = (ts != 2);
        trig_c = (ts != 3); ext_term = (ts != 6);
        pwm_outs = (ts == 5) ? ~(8'h01 << sel) : 8'hFF;
        if (ts == 7) sw_term = 1;
        tick(); idle();
        chk("R4 decoy", active, 1'b1);
        tick();
        chk("R4 decoy staged", active, 1'b1);
        case (ts)
          0: sw_term = 1;
          1: trig_a = 1;
          2: trig_b = 1;
          3: trig_c = 1;
          5: pwm_outs = 8'h01 << sel;
          6: ext_term = 1;
          default: begin
            sw_term = 1; trig_a = 1; trig_b = 1; trig_c = 1;
            pwm_outs = 8'hFF; ext_term = 1;
          end
        endcase
        tick(); idle();
        chk("R4 R7 select", active, ts == 0 || ts == 7);
        tick();
        chk("R8 R4 staged", active, ts == 7);
      end
    end

    // R5 termination qualifier sweep
    term_sel = 3'd1; sync_dis = 1; pwm_sel = 3'd5;
    for (int tq = 0; tq < 8; tq++) begin
      for (int p = 0; p < 32; p++) begin
        logic [4:0] pv;
        pv = p[4:0];
        tq_sel = tq[2:0];
        clear_latch();
        set_latch();
        duty_act = pv[0]; blank_act = pv[1]; gen_trig = pv[2];
        pwm_outs = pv[3] ? 8'h20 : 8'hDF; tq_ext = pv[4]; ext_qual = ~pv[4];
        trig_a = 1;
        tick(); idle();
        chk("R5 term qualifier", active, !selv(tq[2:0], pv));
      end
    end

    // R6 R10 deferred termination
    tq_sel = 3'd0; term_sel = 3'd1; qual_sel = 3'd0;
    clear_latch(); sync_dis = 0;
    set_latch();
    trig_a = 1; eoc = 1; tick(); idle();
    chk("R6 same edge eoc", active, 1'b1);
    tick(); tick();
    chk("R10 pending held", active, 1'b1);
    eoc = 1; tick(); idle();
    chk("R6 eoc clears", active, 1'b0);

    // R9 set wins
    set_latch();
    trig_a = 1; tick(); idle();
    src_in = 1; eoc = 1; tick(); idle();
    chk("R9 set wins sync", active, 1'b1);
    eoc = 1; tick(); idle();
    chk("R9 pending consumed", active, 1'b1);
    sync_dis = 1; src_in = 1; trig_a = 1; tick(); idle();
    chk("R9 set wins immediate", active, 1'b1);

    // R10 pending while inactive
    clear_latch(); sync_dis = 0;
    trig_a = 1; tick(); idle();
    chk("R10 idle", active, 1'b0);
    src_in = 1; tick(); idle();
    chk("R10 set after request", active, 1'b1);
    eoc = 1; tick(); idle();
    chk("R10 pending applied", active, 1'b0);

    // R8 software request setup
    term_sel = 3'd0;
    set_latch();
    sw_term = 1; tick(); idle();
    eoc = 1; tick(); idle();
    chk("R8 eoc one edge after", active, 1'b1);
    tick();
    chk("R8 still pending", active, 1'b1);
    eoc = 1; tick(); idle();
    chk("R8 following eoc", active, 1'b0);
    set_latch();
    sw_term = 1; tick(); idle();
    tick();
    eoc = 1; tick(); idle();
    chk("R8 eoc two edges after", active, 1'b0);

    // R11 reset drops pending
    term_sel = 3'd1;
    clear_latch(); sync_dis = 0;
    trig_a = 1; tick(); idle();
    rst_n = 0; tick(); rst_n = 1;
    chk("R11 reset active", active, 1'b0);
    set_latch();
    eoc = 1; tick(); idle();
    chk("R11 pending cleared", active, 1'b1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule